// File: doc/BRIEF.md
# SRAM Page Residency Controller

This block is the per-region controller that decides which fixed-size weight pages live in a small on-package SRAM region placed in front of a slower, larger memory tier. Commands arrive one at a time on a valid/ready port: bring a page in, send a page out, pin or unpin a page, record an access to a page, or deliver one page to several consumers. Every slot holds a metadata record with a saturating hotness count, a pin bit, a source-tier bit, a tenant identifier, a dirty format-state bit and a demotion-legal flag. The controller reads these records to pick a replacement slot without any host involvement.

Fills and writebacks go out on a request/response memory port, one at a time. A writeback of a dirty page always finishes before its slot is refilled. A thermal-pressure input makes the controller refuse speculative page loads with a deferral status while it keeps accepting all other work. An aging tick halves every hotness count, so pages that are no longer used lose their claim to a slot over time.

Top module: `page_res_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, cmd_ready_o is 1, rsp_valid_o, mcast_valid_o and mem_req_valid_o are 0, and every slot is empty.
- R2: A promote (cmd_op_i=0) whose page misses issues one fill request (mem_req_wr_o=0, page and tier of the command). It answers status OK (0) with the chosen slot in the cycle after the fill response. A promote that hits answers OK with the existing slot and causes no memory request.
- R3: The 4-bit hotness count of a slot starts at 0 on fill and saturates at 15. It goes up by one for each hit by promote, multicast or access (cmd_op_i=5). An age_tick_i pulse halves every count, and in a cycle with both, the halving applies first.
- R4: On a miss, the slot chosen is the lowest-index empty slot if there is one. Otherwise it is the valid, unpinned, demotion-legal slot with the lowest hotness, and a tie goes to the lowest index.
- R5: A pinned page (pin cmd_op_i=2, unpin cmd_op_i=3) is never chosen as a victim and stays resident. A demote (cmd_op_i=1) of a pinned page answers REFUSED (2).
- R6: A page promoted with cmd_nodemote_i=1 is not demotion-legal. It is never evicted, and a demote of it answers REFUSED (2).
- R7: A promote or multicast miss with no legal victim answers REFUSED (2). It makes no memory request and leaves all resident pages unchanged.
- R8: An access with cmd_wr_i=1 marks the page dirty. Evicting or demoting a dirty page first issues a writeback (mem_req_wr_o=1, stored page and tier), and the response or fill follows only after the writeback response. A request holds its fields until mem_req_ready_i.
- R9: An access, pin, unpin or demote of a non-resident page answers MISS (1) and changes nothing.
- R10: With thermal_i=1, a promote or multicast with cmd_spec_i=1 answers DEFER (3) in the next cycle and makes no request. Non-speculative commands proceed, and thermal_i never lowers cmd_ready_o.
- R11: A multicast (cmd_op_i=4) raises mcast_valid_o with the command's destination mask in the same cycle as its OK response, after an implicit promote when the page misses.
- R12: A page is resident for a command only if both its page number and tenant match.
- R13: Commands that need no memory access answer in the cycle after acceptance. While a memory operation is pending, cmd_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Controller idle and accepting |
| cmd_op_i | input | 3 | 0 promote, 1 demote, 2 pin, 3 unpin, 4 multicast, 5 access |
| cmd_page_i | input | PAGE_W | Page number |
| cmd_tenant_i | input | TEN_W | Tenant domain |
| cmd_tier_i | input | 1 | Source tier of the page for a load |
| cmd_nodemote_i | input | 1 | Load the page as non-demotable |
| cmd_spec_i | input | 1 | Speculative load |
| cmd_wr_i | input | 1 | Access modifies the page (sets dirty) |
| cmd_mask_i | input | MASK_W | Multicast destination mask |
| thermal_i | input | 1 | Thermal pressure |
| age_tick_i | input | 1 | Halve all hotness counts |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 2 | 0 OK, 1 MISS, 2 REFUSED, 3 DEFER |
| rsp_slot_o | output | SLOT_W | Slot concerned, valid on OK |
| mcast_valid_o | output | 1 | Multicast delivery strobe |
| mcast_mask_o | output | MASK_W | Multicast destinations |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_wr_o | output | 1 | 1 writeback, 0 fill |
| mem_req_page_o | output | PAGE_W | Page of the request |
| mem_req_tier_o | output | 1 | Tier of the request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_rsp_valid_i | input | 1 | Memory completion |

## Verification
Corrupted metadata does not show at once. A wrong hotness or pin bit only appears at the next miss, as a different slot number in the OK response or as a writeback of the wrong page. For that reason the scenarios force evictions soon after each metadata change: ties after aging, pinned and non-demotable neighbours, and dirty victims. A bad sequencing state shows up within a cycle or two as a request or ready mismatch, and the reference model compares these on every clock.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int HOT_W = 4;

  typedef enum logic [2:0] {
    OP_PROMOTE = 3'd0,
    OP_DEMOTE  = 3'd1,
    OP_PIN     = 3'd2,
    OP_UNPIN   = 3'd3,
    OP_MCAST   = 3'd4,
    OP_ACCESS  = 3'd5
  } pr_op_e;

  typedef enum logic [1:0] {
    RS_OK      = 2'd0,
    RS_MISS    = 2'd1,
    RS_REFUSED = 2'd2,
    RS_DEFER   = 2'd3
  } pr_status_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WB_REQ, ST_WB_WAIT, ST_FILL_REQ, ST_FILL_WAIT
  } pr_state_e;

  function automatic logic [HOT_W-1:0] hot_inc(input logic [HOT_W-1:0] h);
    return (h == '1) ? h : h + 1'b1;
  endfunction
endpackage

// File: rtl/pr_lookup.sv
module pr_lookup #(
  parameter int NUM_SLOTS = 4,
  parameter int PAGE_W    = 8,
  parameter int TEN_W     = 2,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0]             valid_i,
  input  logic [NUM_SLOTS-1:0][PAGE_W-1:0] page_i,
  input  logic [NUM_SLOTS-1:0][TEN_W-1:0]  tenant_i,
  input  logic [PAGE_W-1:0]                key_page_i,
  input  logic [TEN_W-1:0]                 key_tenant_i,
  output logic                             hit_o,
  output logic [SLOT_W-1:0]                slot_o
);
  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (valid_i[i] && page_i[i] == key_page_i && tenant_i[i] == key_tenant_i) begin
        hit_o  = 1'b1;
        slot_o = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/pr_victim_sel.sv
module pr_victim_sel
  import pr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0]            valid_i,
  input  logic [NUM_SLOTS-1:0]            pin_i,
  input  logic [NUM_SLOTS-1:0]            legal_i,
  input  logic [NUM_SLOTS-1:0][HOT_W-1:0] hot_i,
  output logic                            found_o,
  output logic [SLOT_W-1:0]               slot_o
);
  logic              free_found, evict_found;
  logic [SLOT_W-1:0] free_slot, evict_slot;
  logic [HOT_W-1:0]  best_hot;

  always_comb begin
    free_found  = 1'b0;
    free_slot   = '0;
    evict_found = 1'b0;
    evict_slot  = '0;
    best_hot    = '1;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(i);
      end
    end
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (valid_i[i] && !pin_i[i] && legal_i[i] && (!evict_found || hot_i[i] < best_hot)) begin
        evict_found = 1'b1;
        evict_slot  = SLOT_W'(i);
        best_hot    = hot_i[i];
      end
    end
    found_o = free_found | evict_found;
    slot_o  = free_found ? free_slot : evict_slot;
  end
endmodule

// File: rtl/page_res_ctrl.sv
module page_res_ctrl
  import pr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PAGE_W    = 8,
  parameter int TEN_W     = 2,
  parameter int MASK_W    = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic [TEN_W-1:0]  cmd_tenant_i,
  input  logic              cmd_tier_i,
  input  logic              cmd_nodemote_i,
  input  logic              cmd_spec_i,
  input  logic              cmd_wr_i,
  input  logic [MASK_W-1:0] cmd_mask_i,
  input  logic              thermal_i,
  input  logic              age_tick_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [SLOT_W-1:0] rsp_slot_o,
  output logic              mcast_valid_o,
  output logic [MASK_W-1:0] mcast_mask_o,
  output logic              mem_req_valid_o,
  output logic              mem_req_wr_o,
  output logic [PAGE_W-1:0] mem_req_page_o,
  output logic              mem_req_tier_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i
);
  // slot metadata
  logic [NUM_SLOTS-1:0]             slot_valid_q, slot_pin_q, slot_legal_q;
  logic [NUM_SLOTS-1:0]             slot_dirty_q, slot_tier_q;
  logic [NUM_SLOTS-1:0][PAGE_W-1:0] slot_page_q;
  logic [NUM_SLOTS-1:0][TEN_W-1:0]  slot_ten_q;
  logic [NUM_SLOTS-1:0][HOT_W-1:0]  hot_q, hot_aged;

  pr_state_e         state_q;
  pr_op_e            p_op_q, op;
  logic [SLOT_W-1:0] p_slot_q;
  logic [PAGE_W-1:0] p_page_q;
  logic [TEN_W-1:0]  p_ten_q;
  logic              p_tier_q, p_nodemote_q;
  logic [MASK_W-1:0] p_mask_q;

  logic              rsp_valid_q, mcast_valid_q;
  pr_status_e        rsp_status_q;
  logic [SLOT_W-1:0] rsp_slot_q;
  logic [MASK_W-1:0] mcast_mask_q;

  logic              hit, vic_found, spec_blk;
  logic [SLOT_W-1:0] hit_slot, vic_slot;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      hot_aged[i] = age_tick_i ? (hot_q[i] >> 1) : hot_q[i];
  end

  pr_lookup #(.NUM_SLOTS(NUM_SLOTS), .PAGE_W(PAGE_W), .TEN_W(TEN_W)) u_lookup (
    .valid_i     (slot_valid_q),
    .page_i      (slot_page_q),
    .tenant_i    (slot_ten_q),
    .key_page_i  (cmd_page_i),
    .key_tenant_i(cmd_tenant_i),
    .hit_o       (hit),
    .slot_o      (hit_slot)
  );

  pr_victim_sel #(.NUM_SLOTS(NUM_SLOTS)) u_victim (
    .valid_i(slot_valid_q),
    .pin_i  (slot_pin_q),
    .legal_i(slot_legal_q),
    .hot_i  (hot_aged),
    .found_o(vic_found),
    .slot_o (vic_slot)
  );

  assign op       = pr_op_e'(cmd_op_i);
  assign spec_blk = thermal_i && cmd_spec_i && (op == OP_PROMOTE || op == OP_MCAST);

  assign cmd_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
  assign mem_req_wr_o    = (state_q == ST_WB_REQ);
  assign mem_req_page_o  = (state_q == ST_WB_REQ) ? slot_page_q[p_slot_q] : p_page_q;
  assign mem_req_tier_o  = (state_q == ST_WB_REQ) ? slot_tier_q[p_slot_q] : p_tier_q;
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_status_o    = rsp_status_q;
  assign rsp_slot_o      = rsp_slot_q;
  assign mcast_valid_o   = mcast_valid_q;
  assign mcast_mask_o    = mcast_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_valid_q  <= '0;
      slot_pin_q    <= '0;
      slot_legal_q  <= '0;
      slot_dirty_q  <= '0;
      slot_tier_q   <= '0;
      slot_page_q   <= '0;
      slot_ten_q    <= '0;
      hot_q         <= '0;
      state_q       <= ST_IDLE;
      p_op_q        <= OP_PROMOTE;
      p_slot_q      <= '0;
      p_page_q      <= '0;
      p_ten_q       <= '0;
      p_tier_q      <= 1'b0;
      p_nodemote_q  <= 1'b0;
      p_mask_q      <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_status_q  <= RS_OK;
      rsp_slot_q    <= '0;
      mcast_valid_q <= 1'b0;
      mcast_mask_q  <= '0;
    end else begin
      rsp_valid_q   <= 1'b0;
      mcast_valid_q <= 1'b0;
      hot_q         <= hot_aged;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          rsp_valid_q  <= 1'b1;
          rsp_status_q <= RS_OK;
          rsp_slot_q   <= hit ? hit_slot : '0;
          case (op)
            OP_ACCESS: begin
              if (!hit) rsp_status_q <= RS_MISS;
              else begin
                hot_q[hit_slot] <= hot_inc(hot_aged[hit_slot]);
                if (cmd_wr_i) slot_dirty_q[hit_slot] <= 1'b1;
              end
            end
            OP_PIN, OP_UNPIN: begin
              if (!hit) rsp_status_q <= RS_MISS;
              else slot_pin_q[hit_slot] <= (op == OP_PIN);
            end
            OP_DEMOTE: begin
              if (!hit) rsp_status_q <= RS_MISS;
              else if (slot_pin_q[hit_slot] || !slot_legal_q[hit_slot]) rsp_status_q <= RS_REFUSED;
              else if (slot_dirty_q[hit_slot]) begin
                rsp_valid_q <= 1'b0;
                p_op_q      <= OP_DEMOTE;
                p_slot_q    <= hit_slot;
                state_q     <= ST_WB_REQ;
              end else slot_valid_q[hit_slot] <= 1'b0;
            end
            OP_PROMOTE, OP_MCAST: begin
              if (spec_blk) rsp_status_q <= RS_DEFER;
              else if (hit) begin
                hot_q[hit_slot] <= hot_inc(hot_aged[hit_slot]);
                mcast_valid_q   <= (op == OP_MCAST);
                mcast_mask_q    <= cmd_mask_i;
              end else if (!vic_found) rsp_status_q <= RS_REFUSED;
              else begin
                rsp_valid_q            <= 1'b0;
                p_op_q                 <= op;
                p_slot_q               <= vic_slot;
                p_page_q               <= cmd_page_i;
                p_ten_q                <= cmd_tenant_i;
                p_tier_q               <= cmd_tier_i;
                p_nodemote_q           <= cmd_nodemote_i;
                p_mask_q               <= cmd_mask_i;
                slot_valid_q[vic_slot] <= 1'b0;
                state_q <= (slot_valid_q[vic_slot] && slot_dirty_q[vic_slot]) ? ST_WB_REQ
                                                                              : ST_FILL_REQ;
              end
            end
            default: rsp_status_q <= RS_MISS;
          endcase
        end
        ST_WB_REQ:   if (mem_req_ready_i) state_q <= ST_WB_WAIT;
        ST_WB_WAIT:  if (mem_rsp_valid_i) begin
          slot_dirty_q[p_slot_q] <= 1'b0;
          if (p_op_q == OP_DEMOTE) begin
            slot_valid_q[p_slot_q] <= 1'b0;
            rsp_valid_q  <= 1'b1;
            rsp_status_q <= RS_OK;
            rsp_slot_q   <= p_slot_q;
            state_q      <= ST_IDLE;
          end else state_q <= ST_FILL_REQ;
        end
        ST_FILL_REQ: if (mem_req_ready_i) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid_i) begin
          slot_valid_q[p_slot_q] <= 1'b1;
          slot_page_q[p_slot_q]  <= p_page_q;
          slot_ten_q[p_slot_q]   <= p_ten_q;
          slot_tier_q[p_slot_q]  <= p_tier_q;
          slot_pin_q[p_slot_q]   <= 1'b0;
          slot_legal_q[p_slot_q] <= !p_nodemote_q;
          slot_dirty_q[p_slot_q] <= 1'b0;
          hot_q[p_slot_q]        <= '0;
          rsp_valid_q   <= 1'b1;
          rsp_status_q  <= RS_OK;
          rsp_slot_q    <= p_slot_q;
          mcast_valid_q <= (p_op_q == OP_MCAST);
          mcast_mask_q  <= p_mask_q;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_res_ctrl_chk.sv
module page_res_ctrl_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int PAGE_W    = 8
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             cmd_ready_o,
  input logic                             thermal_i,
  input logic                             rsp_valid_o,
  input logic [1:0]                       rsp_status_o,
  input logic                             mcast_valid_o,
  input logic                             mem_req_valid_o,
  input logic                             mem_req_wr_o,
  input logic [PAGE_W-1:0]                mem_req_page_o,
  input logic                             mem_req_ready_i,
  input logic [NUM_SLOTS-1:0]             slot_valid_q,
  input logic [NUM_SLOTS-1:0]             slot_pin_q,
  input logic [NUM_SLOTS-1:0]             slot_legal_q,
  input logic [NUM_SLOTS-1:0][PAGE_W-1:0] slot_page_q
);
  assert_busy_blocks_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !cmd_ready_o);

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_wr_o) && $stable(mem_req_page_o));

  assert_mcast_with_ok_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcast_valid_o |-> rsp_valid_o && rsp_status_o == 2'd0);

  assert_defer_needs_heat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_status_o == 2'd3 |-> $past(thermal_i));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assert_pinned_stays_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_valid_q[i] && slot_pin_q[i] |=> slot_valid_q[i] && $stable(slot_page_q[i]));
    assert_nodemote_stays_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_valid_q[i] && !slot_legal_q[i] |=> slot_valid_q[i] && $stable(slot_page_q[i]));
  end
endmodule

bind page_res_ctrl page_res_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS), .PAGE_W(PAGE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_ready_o    (cmd_ready_o),
  .thermal_i      (thermal_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_status_o   (rsp_status_o),
  .mcast_valid_o  (mcast_valid_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_wr_o   (mem_req_wr_o),
  .mem_req_page_o (mem_req_page_o),
  .mem_req_ready_i(mem_req_ready_i),
  .slot_valid_q   (slot_valid_q),
  .slot_pin_q     (slot_pin_q),
  .slot_legal_q   (slot_legal_q),
  .slot_page_q    (slot_page_q)
);

// File: tb/page_res_ctrl_test.sv
module page_res_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0, cmd_ready_o;
  logic [2:0] cmd_op_i = '0;
  logic [7:0] cmd_page_i = '0;
  logic [1:0] cmd_tenant_i = '0;
  logic       cmd_tier_i = 1'b0, cmd_nodemote_i = 1'b0, cmd_spec_i = 1'b0, cmd_wr_i = 1'b0;
  logic [3:0] cmd_mask_i = '0;
  logic       thermal_i = 1'b0, age_tick_i = 1'b0;
  logic       rsp_valid_o, mcast_valid_o, mem_req_valid_o, mem_req_wr_o, mem_req_tier_o;
  logic [1:0] rsp_status_o, rsp_slot_o;
  logic [3:0] mcast_mask_o;
  logic [7:0] mem_req_page_o;
  logic       mem_req_ready_i = 1'b0, mem_rsp_valid_i = 1'b0;

  int tests = 0, fails = 0, cyc = 0, wb_cnt = 0, req_cnt = 0, wb_page = -1;

  always #2.5 clk_i = ~clk_i;

  page_res_ctrl uut (.*);

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // reference model state
  int m_v[N], m_pg[N], m_tn[N], m_tr[N], m_hot[N], m_pin[N], m_lg[N], m_dt[N];
  int m_st = 0, m_rv = 0, m_rs = 0, m_rsl = 0, m_mv = 0, m_mm = 0;
  int m_ps, m_pop, m_pp, m_ptn, m_ptr, m_pnd, m_pmask;

  function automatic int sat(input int h);
    return (h >= 15) ? 15 : h + 1;
  endfunction

  task automatic model_cmd();
    int h, vic, op;
    op = cmd_op_i;
    h = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] != 0 && m_pg[i] == cmd_page_i && m_tn[i] == cmd_tenant_i) h = i;
    m_rv = 1; m_rs = 0; m_rsl = (h < 0) ? 0 : h;
    case (op)
      5: if (h < 0) m_rs = 1;
         else begin m_hot[h] = sat(m_hot[h]); if (cmd_wr_i) m_dt[h] = 1; end
      2, 3: if (h < 0) m_rs = 1; else m_pin[h] = (op == 2);
      1: if (h < 0) m_rs = 1;
         else if (m_pin[h] != 0 || m_lg[h] == 0) m_rs = 2;
         else if (m_dt[h] != 0) begin m_rv = 0; m_ps = h; m_pop = 1; m_st = 1; end
         else m_v[h] = 0;
      0, 4: begin
        if (thermal_i && cmd_spec_i) m_rs = 3;
        else if (h >= 0) begin
          m_hot[h] = sat(m_hot[h]);
          if (op == 4) begin m_mv = 1; m_mm = cmd_mask_i; end
        end else begin
          vic = -1;
          for (int i = N - 1; i >= 0; i--) if (m_v[i] == 0) vic = i;
          if (vic < 0)
            for (int i = 0; i < N; i++)
              if (m_pin[i] == 0 && m_lg[i] != 0 && (vic < 0 || m_hot[i] < m_hot[vic])) vic = i;
          if (vic < 0) m_rs = 2;
          else begin
            m_rv = 0; m_ps = vic; m_pop = op; m_pp = cmd_page_i; m_ptn = cmd_tenant_i;
            m_ptr = cmd_tier_i; m_pnd = cmd_nodemote_i; m_pmask = cmd_mask_i;
            m_st = (m_dt[vic] != 0) ? 1 : 3;
            m_v[vic] = 0;
          end
        end
      end
      default: m_rs = 1;
    endcase
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_st = 0; m_rv = 0; m_mv = 0;
      for (int i = 0; i < N; i++) begin
        m_v[i] = 0; m_pin[i] = 0; m_lg[i] = 0; m_dt[i] = 0; m_hot[i] = 0;
        m_pg[i] = 0; m_tn[i] = 0; m_tr[i] = 0;
      end
    end else begin
      m_rv = 0; m_mv = 0;
      if (age_tick_i) for (int i = 0; i < N; i++) m_hot[i] = m_hot[i] / 2;
      case (m_st)
        0: if (cmd_valid_i) model_cmd();
        1: if (mem_req_ready_i) m_st = 2;
        2: if (mem_rsp_valid_i) begin
          m_dt[m_ps] = 0;
          if (m_pop == 1) begin m_v[m_ps] = 0; m_rv = 1; m_rs = 0; m_rsl = m_ps; m_st = 0; end
          else m_st = 3;
        end
        3: if (mem_req_ready_i) m_st = 4;
        4: if (mem_rsp_valid_i) begin
          m_v[m_ps] = 1; m_pg[m_ps] = m_pp; m_tn[m_ps] = m_ptn; m_tr[m_ps] = m_ptr;
          m_pin[m_ps] = 0; m_lg[m_ps] = (m_pnd == 0); m_dt[m_ps] = 0; m_hot[m_ps] = 0;
          m_rv = 1; m_rs = 0; m_rsl = m_ps;
          if (m_pop == 4) begin m_mv = 1; m_mm = m_pmask; end
          m_st = 0;
        end
        default: m_st = 0;
      endcase
    end
  end

  // memory responder, watchdog, per-cycle model comparison
  always @(negedge clk_i) begin
    int ep, et;
    cyc++;
    mem_req_ready_i = (cyc % 3 != 0);
    mem_rsp_valid_i = (cyc % 4 == 1);
    if (mem_req_valid_o && mem_req_ready_i) begin
      req_cnt++;
      if (mem_req_wr_o) begin wb_cnt++; wb_page = mem_req_page_o; end
    end
    if (rst_ni) begin
      ep = (m_st == 1) ? m_pg[m_ps] : m_pp;
      et = (m_st == 1) ? m_tr[m_ps] : m_ptr;
      chk(cmd_ready_o == (m_st == 0), "R13 model cmd_ready", cmd_ready_o, m_st == 0);
      chk(mem_req_valid_o == (m_st == 1 || m_st == 3), "R13 model mem_req_valid",
          mem_req_valid_o, m_st == 1 || m_st == 3);
      if (m_st == 1 || m_st == 3) begin
        chk(mem_req_wr_o == (m_st == 1), "R8 model mem_req_wr", mem_req_wr_o, m_st == 1);
        chk(mem_req_page_o == 8'(ep), "R8 model mem_req_page", mem_req_page_o, ep);
        chk(mem_req_tier_o == 1'(et), "R2 model mem_req_tier", mem_req_tier_o, et);
      end
      chk(rsp_valid_o == (m_rv != 0), "R13 model rsp_valid", rsp_valid_o, m_rv);
      if (m_rv != 0) begin
        chk(rsp_status_o == 2'(m_rs), "R9 model rsp_status", rsp_status_o, m_rs);
        if (m_rs == 0) chk(rsp_slot_o == 2'(m_rsl), "R4 model rsp_slot", rsp_slot_o, m_rsl);
      end
      chk(mcast_valid_o == (m_mv != 0), "R11 model mcast_valid", mcast_valid_o, m_mv);
      if (m_mv != 0) chk(mcast_mask_o == 4'(m_mm), "R11 model mcast_mask", mcast_mask_o, m_mm);
    end
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_cmd(input int op, input int pg, input int tn, input bit nodem,
                        input bit spec, input bit wr, input int mask,
                        input int exp_st, input int exp_sl, input bit exp_mc, input string tag);
    cmd_op_i = 3'(op); cmd_page_i = 8'(pg); cmd_tenant_i = 2'(tn); cmd_tier_i = 1'(pg % 2);
    cmd_nodemote_i = nodem; cmd_spec_i = spec; cmd_wr_i = wr; cmd_mask_i = 4'(mask);
    cmd_valid_i = 1'b1;
    while (!cmd_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    chk(rsp_status_o == 2'(exp_st), {tag, " status"}, rsp_status_o, exp_st);
    if (exp_st == 0) chk(rsp_slot_o == 2'(exp_sl), {tag, " slot"}, rsp_slot_o, exp_sl);
    chk(mcast_valid_o == exp_mc, {tag, " mcast_valid"}, mcast_valid_o, exp_mc);
    if (exp_mc) chk(mcast_mask_o == 4'(mask), {tag, " mcast_mask"}, mcast_mask_o, mask);
    @(negedge clk_i);
  endtask

  initial begin
    int wb0, rq0;
    repeat (3) @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1 reset cmd_ready", cmd_ready_o, 1);
    chk(rsp_valid_o == 1'b0 && mcast_valid_o == 1'b0, "R1 reset strobes", rsp_valid_o, 0);
    chk(mem_req_valid_o == 1'b0, "R1 reset mem_req_valid", mem_req_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_cmd(5, 10, 0, 0, 0, 0, 0, 1, 0, 0, "R1 empty after reset access");
    // fill all slots; page 13 non-demotable
    do_cmd(0, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R2 promote miss 10");
    do_cmd(0, 11, 0, 0, 0, 0, 0, 0, 1, 0, "R4 promote 11 free slot");
    do_cmd(0, 12, 0, 0, 0, 0, 0, 0, 2, 0, "R4 promote 12 free slot");
    do_cmd(0, 13, 0, 1, 0, 0, 0, 0, 3, 0, "R6 promote 13 nodemote");
    rq0 = req_cnt;
    do_cmd(0, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R2 promote hit 10");
    chk(req_cnt == rq0, "R2 promote hit no memory traffic", req_cnt, rq0);
    do_cmd(5, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R3 access 10");
    do_cmd(5, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R3 access 10");
    do_cmd(5, 11, 0, 0, 0, 0, 0, 0, 1, 0, "R3 access 11");
    do_cmd(5, 12, 0, 0, 0, 1, 0, 0, 2, 0, "R8 write access 12");
    do_cmd(5, 12, 0, 0, 0, 1, 0, 0, 2, 0, "R8 write access 12");
    do_cmd(5, 99, 0, 0, 0, 0, 0, 1, 0, 0, "R9 access miss");
    do_cmd(5, 13, 1, 0, 0, 0, 0, 1, 0, 0, "R12 tenant mismatch");
    do_cmd(5, 13, 0, 0, 0, 0, 0, 0, 3, 0, "R12 tenant match");
    do_cmd(2, 11, 0, 0, 0, 0, 0, 0, 1, 0, "R5 pin 11");
    do_cmd(2, 50, 0, 0, 0, 0, 0, 1, 0, 0, "R9 pin miss");
    // hot: s0=3 s1=1 pinned s2=2 dirty s3 nodemote -> victim s2 with writeback
    wb0 = wb_cnt;
    do_cmd(0, 20, 0, 0, 0, 0, 0, 0, 2, 0, "R4 evict coldest legal");
    chk(wb_cnt == wb0 + 1, "R8 dirty victim writeback count", wb_cnt, wb0 + 1);
    chk(wb_page == 12, "R8 writeback page", wb_page, 12);
    do_cmd(5, 12, 0, 0, 0, 0, 0, 1, 0, 0, "R9 evicted page miss");
    do_cmd(5, 11, 0, 0, 0, 0, 0, 0, 1, 0, "R5 pinned page still resident");
    wb0 = wb_cnt;
    do_cmd(0, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R4 clean victim s2");
    chk(wb_cnt == wb0, "R8 clean victim no writeback", wb_cnt, wb0);
    do_cmd(5, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R3 access 21");
    do_cmd(5, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R3 access 21");
    // age: s0 3->1, s2 2->1, tie -> lowest index
    age_tick_i = 1'b1;
    @(negedge clk_i);
    age_tick_i = 1'b0;
    do_cmd(0, 22, 0, 0, 0, 0, 0, 0, 0, 0, "R3 R4 aged tie lowest slot");
    do_cmd(5, 10, 0, 0, 0, 0, 0, 1, 0, 0, "R4 aged page evicted");
    do_cmd(1, 13, 0, 0, 0, 0, 0, 2, 0, 0, "R6 demote nodemote refused");
    do_cmd(1, 11, 0, 0, 0, 0, 0, 2, 0, 0, "R5 demote pinned refused");
    do_cmd(3, 11, 0, 0, 0, 0, 0, 0, 1, 0, "R5 unpin 11");
    do_cmd(1, 11, 0, 0, 0, 0, 0, 0, 1, 0, "R2 demote clean");
    do_cmd(1, 11, 0, 0, 0, 0, 0, 1, 0, 0, "R9 demote miss");
    // thermal pressure
    thermal_i = 1'b1;
    rq0 = req_cnt;
    do_cmd(0, 30, 0, 0, 1, 0, 0, 3, 0, 0, "R10 spec promote deferred");
    chk(req_cnt == rq0, "R10 deferred no request", req_cnt, rq0);
    chk(cmd_ready_o == 1'b1, "R10 no stall under heat", cmd_ready_o, 1);
    do_cmd(0, 30, 0, 0, 0, 0, 0, 0, 1, 0, "R10 non-spec promote proceeds");
    thermal_i = 1'b0;
    // multicast
    do_cmd(4, 40, 0, 0, 0, 0, 10, 0, 0, 1, "R11 mcast implicit promote");
    do_cmd(4, 30, 0, 0, 0, 0, 6, 0, 1, 1, "R11 mcast resident");
    // no legal victim
    do_cmd(2, 40, 0, 0, 0, 0, 0, 0, 0, 0, "R5 pin 40");
    do_cmd(2, 30, 0, 0, 0, 0, 0, 0, 1, 0, "R5 pin 30");
    do_cmd(2, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R5 pin 21");
    rq0 = req_cnt;
    do_cmd(0, 50, 0, 0, 0, 0, 0, 2, 0, 0, "R7 no victim refused");
    do_cmd(4, 51, 0, 0, 0, 0, 3, 2, 0, 0, "R7 mcast no victim refused");
    chk(req_cnt == rq0, "R7 no memory traffic", req_cnt, rq0);
    do_cmd(5, 40, 0, 0, 0, 0, 0, 0, 0, 0, "R7 metadata intact 40");
    do_cmd(5, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R7 metadata intact 21");
    // dirty demote
    do_cmd(3, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R5 unpin 21");
    do_cmd(5, 21, 0, 0, 0, 1, 0, 0, 2, 0, "R8 write access 21");
    wb0 = wb_cnt;
    do_cmd(1, 21, 0, 0, 0, 0, 0, 0, 2, 0, "R8 demote dirty");
    chk(wb_cnt == wb0 + 1, "R8 demote writeback count", wb_cnt, wb0 + 1);
    chk(wb_page == 21, "R8 demote writeback page", wb_page, 21);
    do_cmd(5, 21, 0, 0, 0, 0, 0, 1, 0, 0, "R9 demoted page miss");
    // saturation: 20 hits on 40, then free slot 2 taken, s0 stays
    for (int k = 0; k < 20; k++) do_cmd(5, 40, 0, 0, 0, 0, 0, 0, 0, 0, "R3 saturating access");
    do_cmd(0, 60, 0, 0, 0, 0, 0, 0, 2, 0, "R4 empty slot preferred");
    repeat (4) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule